// File: doc/BRIEF.md
# Event-Driven Interrupt Aggregator

This block collects pulse events from a set of hardware event sources and turns them into level interrupts for a host. Each source has a pair of one-cycle inputs. An up pulse means "something is pending" and a down pulse means "the pending condition has gone away". A per-source routing register sends both pulses of that source to one bit of one interrupt group's status word. The group's interrupt line is the OR of its status bits, each gated by the group's enable mask.

Software sees the block through a flat register port with single-cycle writes and combinational reads. The port gives access to the routing registers, the status words, a write-ones-to-set alias of each status word for test, and the enable masks. Software never clears a status bit directly. Bits fall only when the source that raised them signals down, so the interrupt line follows the pending state of the queues behind it.

Top module: `evtagg_top`

## Requirements
- R1: An up pulse on source s sets the status bit chosen by s's routing register. The bit reads back as set from the cycle after the pulse.
- R2: `irq_o[g]` is high in every cycle in which group g has at least one status bit set whose enable bit is also set.
- R3: A down pulse on source s clears the status bit chosen by s's routing register on the next clock edge.
- R4: An interrupt line stays high while any enabled bit of its group remains set. It falls only after the last enabled bit has been cleared or disabled.
- R5: A routing register holds the bit index in bits [2:0] and the group index in bit [3], and reads back the value written. A rewrite redirects later events of that source.
- R6: Writing to the status-set alias of group g sets every status bit where the write data is 1. Data bits of 0 leave the matching status bits unchanged.
- R7: When an up pulse and a down pulse reach the same status bit in the same cycle, the bit ends up set.
- R8: A status bit whose enable bit is 0 is still recorded in the status word, but it does not drive the interrupt line.
- R9: Several sources routed to the same bit act as an OR. A down pulse from any one of them clears the bit.
- R10: After reset, all status words, enable masks and routing registers read 0, and all interrupt lines are low.
- R11: Writes to the plain status address are ignored. Address bits [5:4] select the space: 0 routing, 1 status, 2 status-set, 3 enable. Bits [3:0] give the source or group index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_up_i | input | NUM_SRC | One-cycle up pulse per source |
| evt_dn_i | input | NUM_SRC | One-cycle down pulse per source |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register address: space in [5:4], index in [3:0] |
| reg_wdata_i | input | GRP_BITS | Register write data |
| reg_rdata_o | output | GRP_BITS | Register read data, combinational from address |
| irq_o | output | NUM_GRP | Interrupt line per group |

## Verification
The hardest situations to reach are collisions on one status bit. These are an up and a down pulse in the same cycle, and two sources sharing a bit where one of them withdraws. Each needs the routing registers set up first, so that distinct sources land on the same target. The bench therefore programs a deliberately overlapping routing table, then walks a vector table that fires coincident and overlapping pulses. After every step it reads both status words and the interrupt lines. Directed steps then cover the set alias, ignored writes to the status address, and rerouting a source.

// File: rtl/evtagg_pkg.sv
// Package: shared address-space codes and fixed field widths for the
// event interrupt aggregator. Assumes index fields are 4 bits wide.
package evtagg_pkg;
    localparam int IDX_W  = 4;
    localparam int ADDR_W = IDX_W + 2;

    typedef enum logic [1:0] {
        SP_ROUTE  = 2'd0,
        SP_STATUS = 2'd1,
        SP_SET    = 2'd2,
        SP_ENABLE = 2'd3
    } space_e;
endpackage

// File: rtl/evtagg_route.sv
// Module: routing registers, one per event source, plus the decode that
// turns up/down pulses into per-bit set/clear vectors for every group.
// Assumes NUM_SRC <= 16 and routing values are {group, bit}.
module evtagg_route #(
    parameter int NUM_SRC  = 8,
    parameter int NUM_GRP  = 2,
    parameter int GRP_BITS = 8,
    parameter int GRP_W    = 1,
    parameter int BIT_W    = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_SRC-1:0]            up_i,
    input  logic [NUM_SRC-1:0]            dn_i,
    input  logic                          wr_i,
    input  logic [evtagg_pkg::IDX_W-1:0]  idx_i,
    input  logic [GRP_W+BIT_W-1:0]        wdata_i,
    output logic [GRP_W+BIT_W-1:0]        rdata_o,
    output logic [NUM_GRP*GRP_BITS-1:0]   set_o,
    output logic [NUM_GRP*GRP_BITS-1:0]   clr_o
);
    localparam int MAP_W = GRP_W + BIT_W;

    logic [MAP_W-1:0] route_q [NUM_SRC];
    logic             idx_ok;

    // Index range check shared by write and read
    assign idx_ok = ({1'b0, idx_i} < (evtagg_pkg::IDX_W+1)'(NUM_SRC));

    // Routing register storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SRC; s++) route_q[s] <= '0;
        end else if (wr_i && idx_ok) begin
            route_q[idx_i[$clog2(NUM_SRC > 1 ? NUM_SRC : 2)-1:0]] <= wdata_i;
        end
    end

    // Readback of the addressed routing register
    always_comb begin
        rdata_o = '0;
        for (int s = 0; s < NUM_SRC; s++)
            if (idx_ok && (idx_i == evtagg_pkg::IDX_W'(s))) rdata_o = route_q[s];
    end

    // Fan each source's pulses out to the group bit it is routed to
    always_comb begin
        set_o = '0;
        clr_o = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            for (int g = 0; g < NUM_GRP; g++) begin
                for (int b = 0; b < GRP_BITS; b++) begin
                    if (route_q[s] == {GRP_W'(g), BIT_W'(b)}) begin
                        set_o[g*GRP_BITS+b] = set_o[g*GRP_BITS+b] | up_i[s];
                        clr_o[g*GRP_BITS+b] = clr_o[g*GRP_BITS+b] | dn_i[s];
                    end
                end
            end
        end
    end

    AST_ROUTE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> (rdata_o == $past(rdata_o)) || (idx_i != $past(idx_i))) // R5
        else $error("routing register changed without a write");
endmodule

// File: rtl/evtagg_grp.sv
// Module: one interrupt group. Holds the status word and enable mask and
// drives the group's interrupt line. Assumes set/clear inputs are already
// decoded per bit; any set source (event or software) beats a clear.
module evtagg_grp #(
    parameter int GRP_BITS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [GRP_BITS-1:0] evt_set_i,
    input  logic [GRP_BITS-1:0] evt_clr_i,
    input  logic [GRP_BITS-1:0] sw_set_i,
    input  logic                en_we_i,
    input  logic [GRP_BITS-1:0] en_wdata_i,
    output logic [GRP_BITS-1:0] status_o,
    output logic [GRP_BITS-1:0] enable_o,
    output logic                irq_o
);
    logic [GRP_BITS-1:0] set_all;

    // Combine event and software set requests
    assign set_all = evt_set_i | sw_set_i;

    // Status word: set wins over clear, otherwise hold
    always_ff @(posedge clk) begin
        if (!rst_n) status_o <= '0;
        else        status_o <= set_all | (status_o & ~evt_clr_i);
    end

    // Enable mask register
    always_ff @(posedge clk) begin
        if (!rst_n)       enable_o <= '0;
        else if (en_we_i) enable_o <= en_wdata_i;
    end

    // Interrupt line: any enabled pending bit
    assign irq_o = |(status_o & enable_o);

    AST_UP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_all != '0) |=> ((status_o & $past(set_all)) == $past(set_all))) // R1
        else $error("set request did not set status");

    AST_DN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_clr_i & ~set_all) != '0) |=> ((status_o & $past(evt_clr_i & ~set_all)) == '0)) // R3
        else $error("down event did not clear status");

    AST_IRQ_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o) |-> $past((evt_clr_i != '0) || en_we_i)) // R4
        else $error("interrupt fell without clear or enable change");

    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (set_all == '0 && evt_clr_i == '0) |=> $stable(status_o)) // R2
        else $error("status moved without a request");
endmodule

// File: rtl/evtagg_top.sv
// Module: event interrupt aggregator top. Decodes the register port into
// routing, status-set and enable writes, instantiates one group block per
// interrupt line, and muxes read data. Assumes NUM_GRP <= 16 and that the
// routing value width fits in GRP_BITS.
module evtagg_top #(
    parameter int NUM_SRC  = 8,
    parameter int NUM_GRP  = 2,
    parameter int GRP_BITS = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_SRC-1:0]             evt_up_i,
    input  logic [NUM_SRC-1:0]             evt_dn_i,
    input  logic                           reg_wr_i,
    input  logic [evtagg_pkg::ADDR_W-1:0]  reg_addr_i,
    input  logic [GRP_BITS-1:0]            reg_wdata_i,
    output logic [GRP_BITS-1:0]            reg_rdata_o,
    output logic [NUM_GRP-1:0]             irq_o
);
    import evtagg_pkg::*;

    localparam int GRP_W = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1;
    localparam int BIT_W = (GRP_BITS > 1) ? $clog2(GRP_BITS) : 1;
    localparam int MAP_W = GRP_W + BIT_W;

    space_e                      space;
    logic [IDX_W-1:0]            idx;
    logic [MAP_W-1:0]            route_rd;
    logic [NUM_GRP*GRP_BITS-1:0] set_vec;
    logic [NUM_GRP*GRP_BITS-1:0] clr_vec;
    logic [GRP_BITS-1:0]         status_w [NUM_GRP];
    logic [GRP_BITS-1:0]         enable_w [NUM_GRP];

    assign space = space_e'(reg_addr_i[ADDR_W-1:IDX_W]);
    assign idx   = reg_addr_i[IDX_W-1:0];

    evtagg_route #(
        .NUM_SRC (NUM_SRC),
        .NUM_GRP (NUM_GRP),
        .GRP_BITS(GRP_BITS),
        .GRP_W   (GRP_W),
        .BIT_W   (BIT_W)
    ) i_route (
        .clk    (clk),
        .rst_n  (rst_n),
        .up_i   (evt_up_i),
        .dn_i   (evt_dn_i),
        .wr_i   (reg_wr_i && (space == SP_ROUTE)),
        .idx_i  (idx),
        .wdata_i(reg_wdata_i[MAP_W-1:0]),
        .rdata_o(route_rd),
        .set_o  (set_vec),
        .clr_o  (clr_vec)
    );

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        logic sel;
        // Group selected by the current register address
        assign sel = (idx == IDX_W'(g));

        evtagg_grp #(.GRP_BITS(GRP_BITS)) i_grp (
            .clk       (clk),
            .rst_n     (rst_n),
            .evt_set_i (set_vec[g*GRP_BITS +: GRP_BITS]),
            .evt_clr_i (clr_vec[g*GRP_BITS +: GRP_BITS]),
            .sw_set_i  ((reg_wr_i && sel && space == SP_SET) ? reg_wdata_i : '0),
            .en_we_i   (reg_wr_i && sel && space == SP_ENABLE),
            .en_wdata_i(reg_wdata_i),
            .status_o  (status_w[g]),
            .enable_o  (enable_w[g]),
            .irq_o     (irq_o[g])
        );
    end

    // Read mux over the four register spaces
    always_comb begin
        reg_rdata_o = '0;
        if (space == SP_ROUTE) begin
            reg_rdata_o = GRP_BITS'(route_rd);
        end else begin
            for (int g = 0; g < NUM_GRP; g++) begin
                if (idx == IDX_W'(g))
                    reg_rdata_o = (space == SP_ENABLE) ? enable_w[g] : status_w[g];
            end
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (irq_o == '0)) // R10
        else $error("interrupt high after reset");
endmodule

// File: tb/test_evtagg_top.sv
module test_evtagg_top;
    localparam int NS = 8;
    localparam int NG = 2;
    localparam int GB = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] up = '0;
    logic [NS-1:0] dn = '0;
    logic          wr = 1'b0;
    logic [5:0]    addr = '0;
    logic [GB-1:0] wdata = '0;
    logic [GB-1:0] rdata;
    logic [NG-1:0] irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    evtagg_top #(.NUM_SRC(NS), .NUM_GRP(NG), .GRP_BITS(GB)) i_evtagg_top (
        .clk(clk), .rst_n(rst_n), .evt_up_i(up), .evt_dn_i(dn),
        .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .irq_o(irq)
    );

    // {up, dn, status g0, status g1, irq}
    localparam logic [33:0] VEC [11] = '{
        {8'h01, 8'h00, 8'h01, 8'h00, 2'b01},  // R1 R2
        {8'h08, 8'h00, 8'h01, 8'h01, 2'b11},  // R1 R2
        {8'h00, 8'h01, 8'h00, 8'h01, 2'b10},  // R3
        {8'h40, 8'h00, 8'h00, 8'h81, 2'b10},  // R4
        {8'h00, 8'h08, 8'h00, 8'h80, 2'b00},  // R4 R8
        {8'h21, 8'h00, 8'h01, 8'h80, 2'b01},  // R9
        {8'h00, 8'h20, 8'h00, 8'h80, 2'b00},  // R9
        {8'h02, 8'h02, 8'h02, 8'h80, 2'b01},  // R7
        {8'h80, 8'h02, 8'h80, 8'h80, 2'b01},  // R3
        {8'h01, 8'h80, 8'h01, 8'h80, 2'b01},  // R3
        {8'h00, 8'h41, 8'h00, 8'h00, 2'b00}   // R3
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [5:0] a, input logic [GB-1:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [5:0] a, input logic [GB-1:0] exp);
        addr = a;
        #1;
        chk(req, 32'(rdata), 32'(exp));
    endtask

    task automatic pulse(input logic [NS-1:0] u, input logic [NS-1:0] d);
        @(negedge clk);
        up = u; dn = d;
        @(negedge clk);
        up = '0; dn = '0;
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 irq", 32'(irq), 32'h0);
        rd_chk("R10 status g0", 6'h10, 8'h00);
        rd_chk("R10 status g1", 6'h11, 8'h00);
        rd_chk("R10 enable g1", 6'h31, 8'h00);
        rd_chk("R10 route s4",  6'h04, 8'h00);

        // R5 routing table: value = {group[3], bit[2:0]}
        wr_reg(6'h00, 8'h00); wr_reg(6'h01, 8'h01);
        wr_reg(6'h02, 8'h02); wr_reg(6'h03, 8'h08);
        wr_reg(6'h04, 8'h0D); wr_reg(6'h05, 8'h00);
        wr_reg(6'h06, 8'h0F); wr_reg(6'h07, 8'h07);
        rd_chk("R5 route s4 readback", 6'h04, 8'h0D);
        rd_chk("R5 route s6 readback", 6'h06, 8'h0F);
        wr_reg(6'h30, 8'hFF);
        wr_reg(6'h31, 8'h21);
        rd_chk("R11 enable g1 readback", 6'h31, 8'h21);
        chk("R8 no irq with empty status", 32'(irq), 32'h0);

        foreach (VEC[i]) begin
            pulse(VEC[i][33:26], VEC[i][25:18]);
            rd_chk($sformatf("R1/R3/R7/R9 vec%0d status g0", i), 6'h10, VEC[i][17:10]);
            rd_chk($sformatf("R1/R3/R7/R9 vec%0d status g1", i), 6'h11, VEC[i][9:2]);
            chk($sformatf("R2/R4/R8 vec%0d irq", i), 32'(irq), 32'(VEC[i][1:0]));
        end

        // R6 status-set alias
        wr_reg(6'h21, 8'h22);
        rd_chk("R6 set alias g1", 6'h11, 8'h22);
        chk("R2 irq after set alias", 32'(irq), 32'h2);
        wr_reg(6'h21, 8'h00);
        rd_chk("R6 zero write no effect", 6'h11, 8'h22);
        // R11 plain status address ignores writes
        wr_reg(6'h11, 8'h00);
        rd_chk("R11 status write ignored", 6'h11, 8'h22);
        rd_chk("R11 status alias read", 6'h21, 8'h22);
        // R8 drop enabled bit, disabled bit1 stays pending
        pulse(8'h10, 8'h00); pulse(8'h00, 8'h10);
        rd_chk("R8 disabled bit kept", 6'h11, 8'h02);
        chk("R8 irq low with only disabled bit", 32'(irq), 32'h0);
        wr_reg(6'h31, 8'h02);
        chk("R2 enable raises irq", 32'(irq), 32'h2);
        // R5 reroute source 3 to group 1 bit 3
        wr_reg(6'h03, 8'h0B);
        pulse(8'h08, 8'h00);
        rd_chk("R5 rerouted target g1", 6'h11, 8'h0A);
        rd_chk("R5 old target untouched g0", 6'h10, 8'h00);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule